// File: doc/BRIEF.md
# Peripheral Clock and Reset Sequencer

This block turns a free-running system clock into a divided peripheral clock enable (`hclk_tick`) and releases two reset outputs in a fixed order: first the reset of the interface glue logic, then the reset of the serial-port core. Software drives the block through one 64-bit control word. The word holds a reset request for each of the two blocks, a 3-bit divide select, a divider reset, a bypass select, a clock enable and a conditional-clock enable. The divide ratios are 1, 2, 4, 6, 8, 16, 24 and 32, so the set is not all powers of two.

The hardware enforces the ordering and does not rely on software to wait. The reset request bits are treated as requests. The glue-logic reset output stays asserted until 20 peripheral clock pulses have passed since the divider started. The core reset output stays asserted until 10 further pulses have passed after the glue reset is released. A third flag reports that 10 more pulses have passed after the core reset is released, which marks when registers clocked only by the peripheral clock may be accessed. Each flag clears as soon as a reset or divider condition it depends on is reasserted.

Top module: `periph_clkrst_seq`

## Requirements
- R1: After the synchronous reset, `rd_data` reads 0x0000_0000_1000_0003 (both reset requests and the divider reset set). `glue_rst` and `core_rst` are 1, and `hclk_tick`, `unit_en`, `hclk_wait_done`, `core_wait_done` and `access_ok` are 0.
- R2: The control word fields are: bit 0 glue reset request, bit 1 core reset request, bit 4 conditional-clock enable, bits 26:24 divide select, bit 28 divider reset, bit 29 bypass, bit 30 clock enable. Every other bit is written as nothing and reads 0, so a write of all ones reads back 0x0000_0000_7700_0013.
- R3: With the divider running and bypass clear, `hclk_tick` is a one-cycle pulse repeating every N system cycles. N is 1, 2, 4, 6, 8, 16, 24 or 32 for select codes 0 to 7.
- R4: With bypass set and the divider running, `hclk_tick` is 1 on every cycle whatever the divide select holds.
- R5: While the divider reset is 1 or the clock enable is 0, `hclk_tick` stays 0.
- R6: `hclk_wait_done` rises after exactly 20 `hclk_tick` pulses have been seen since the divider last started running.
- R7: `glue_rst` stays 1 while the glue request bit is 1 or `hclk_wait_done` is 0.
- R8: `core_wait_done` rises after exactly 10 pulses seen while `glue_rst` is 0. `core_rst` stays 1 while the core request bit is 1, `glue_rst` is 1 or `core_wait_done` is 0, and `core_rst` is never 0 while `glue_rst` is 1.
- R9: `access_ok` rises after exactly 10 pulses seen while `core_rst` is 0.
- R10: Setting the glue request bit again drives both reset outputs back to 1 and clears `core_wait_done` and `access_ok`. Setting the divider reset again also clears `hclk_wait_done`.
- R11: `unit_en` equals bit 4 of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 64 | Control word write value |
| rd_data | output | 64 | Current control word |
| hclk_tick | output | 1 | Divided peripheral clock enable pulse |
| glue_rst | output | 1 | Reset to the interface glue logic |
| core_rst | output | 1 | Reset to the serial-port core |
| unit_en | output | 1 | Conditional-clock enable, reported as the unit enabled state |
| hclk_wait_done | output | 1 | 20-pulse start-up window has passed |
| core_wait_done | output | 1 | 10-pulse window after glue release has passed |
| access_ok | output | 1 | 10-pulse window after core release has passed |

## Verification
The embedded properties check the following on every cycle: the reset ordering (the core is never released ahead of the glue logic), the gating and bypass of the tick, the masking of reserved bits, and that every flag rise coincides with a counted pulse. Some behaviour only the bench scenarios can show. This covers the exact period for each of the eight divide codes, the exact pulse counts of 20, 10 and 10 behind each flag, and the clearing of the flags when a reset request or the divider reset is written again.

// File: rtl/pcrs_pkg.sv
`timescale 1ns/1ps
package pcrs_pkg;
  localparam int CTRL_W   = 64;
  localparam int B_GLUE   = 0;
  localparam int B_CORE   = 1;
  localparam int B_CCLK   = 4;
  localparam int SEL_LO   = 24;
  localparam int SEL_W    = 3;
  localparam int B_DRST   = 28;
  localparam int B_BYP    = 29;
  localparam int B_HEN    = 30;
  localparam int RATIO_W  = 6;

  localparam logic [CTRL_W-1:0] CTRL_MASK  = 64'h0000_0000_7700_0013;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 64'h0000_0000_1000_0003;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    ratio_of = 6'd1;
      3'd1:    ratio_of = 6'd2;
      3'd2:    ratio_of = 6'd4;
      3'd3:    ratio_of = 6'd6;
      3'd4:    ratio_of = 6'd8;
      3'd5:    ratio_of = 6'd16;
      3'd6:    ratio_of = 6'd24;
      default: ratio_of = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/pcrs_ctrl_reg.sv
`timescale 1ns/1ps
module pcrs_ctrl_reg
  import pcrs_pkg::*;
#(
  parameter int W = CTRL_W,
  parameter logic [W-1:0] MASK = CTRL_MASK,
  parameter logic [W-1:0] INIT = CTRL_RESET
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl
);
  always_ff @(posedge clk) begin
    if (rst)        ctrl <= INIT;
    else if (wr_en) ctrl <= wr_data & MASK;
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl & ~MASK) == '0);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ctrl == ($past(wr_data) & MASK));
endmodule

// File: rtl/pcrs_hclk_div.sv
`timescale 1ns/1ps
module pcrs_hclk_div
  import pcrs_pkg::*;
#(
  parameter int CNT_W = RATIO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             bypass,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim = CNT_W'(ratio_of(sel) - 6'd1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (bypass) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R5
  gated_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tick);

  // R4
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (run && bypass) |=> tick);
endmodule

// File: rtl/pcrs_wait_win.sv
`timescale 1ns/1ps
module pcrs_wait_win #(
  parameter int WAIT = 20,
  localparam int CW  = $clog2(WAIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (tick && !done) begin
      cnt  <= cnt + 1'b1;
      if (cnt == CW'(WAIT - 1)) done <= 1'b1;
    end
  end

  // R6
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(tick) && !$past(clr));

  // R10
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !done);
endmodule

// File: rtl/periph_clkrst_seq.sv
`timescale 1ns/1ps
module periph_clkrst_seq
  import pcrs_pkg::*;
#(
  parameter int LONG_WAIT  = 20,
  parameter int SHORT_WAIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              hclk_tick,
  output logic              glue_rst,
  output logic              core_rst,
  output logic              unit_en,
  output logic              hclk_wait_done,
  output logic              core_wait_done,
  output logic              access_ok
);
  logic [CTRL_W-1:0] ctrl;
  logic run;
  logic glue_d;

  pcrs_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ctrl(ctrl)
  );

  assign run = ctrl[B_HEN] && !ctrl[B_DRST];

  pcrs_hclk_div u_div (
    .clk(clk), .rst(rst), .run(run), .bypass(ctrl[B_BYP]),
    .sel(ctrl[SEL_LO +: SEL_W]), .tick(hclk_tick)
  );

  pcrs_wait_win #(.WAIT(LONG_WAIT)) u_win_start (
    .clk(clk), .rst(rst), .clr(!run), .tick(hclk_tick), .done(hclk_wait_done)
  );

  pcrs_wait_win #(.WAIT(SHORT_WAIT)) u_win_glue (
    .clk(clk), .rst(rst), .clr(glue_rst), .tick(hclk_tick), .done(core_wait_done)
  );

  pcrs_wait_win #(.WAIT(SHORT_WAIT)) u_win_core (
    .clk(clk), .rst(rst), .clr(core_rst), .tick(hclk_tick), .done(access_ok)
  );

  assign glue_d = ctrl[B_GLUE] || !hclk_wait_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      glue_rst <= 1'b1;
      core_rst <= 1'b1;
    end else begin
      glue_rst <= glue_d;
      core_rst <= ctrl[B_CORE] || glue_d || !core_wait_done;
    end
  end

  assign rd_data = ctrl;
  assign unit_en = ctrl[B_CCLK];

  // R8
  core_after_glue_chk: assert property (@(posedge clk) disable iff (rst)
    !core_rst |-> !glue_rst);

  // R7
  glue_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hclk_wait_done |=> glue_rst);

  // R8
  core_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !core_wait_done |=> core_rst);

  // R9
  access_gate_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> !access_ok);
endmodule

// File: tb/tb_periph_clkrst_seq.sv
`timescale 1ns/1ps
module tb_periph_clkrst_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic hclk_tick, glue_rst, core_rst, unit_en;
  logic hclk_wait_done, core_wait_done, access_ok;

  int checks = 0;
  int fails  = 0;

  localparam logic [63:0] HEN  = 64'h4000_0000;
  localparam logic [63:0] BYP  = 64'h2000_0000;
  localparam logic [63:0] DRST = 64'h1000_0000;
  localparam logic [63:0] CCLK = 64'h0000_0010;

  // {bypass, select, expected pulses in 96 cycles}
  localparam logic [10:0] VEC [0:8] = '{
    {1'b0, 3'd0, 7'd96}, {1'b0, 3'd1, 7'd48}, {1'b0, 3'd2, 7'd24},
    {1'b0, 3'd3, 7'd16}, {1'b0, 3'd4, 7'd12}, {1'b0, 3'd5, 7'd6},
    {1'b0, 3'd6, 7'd4},  {1'b0, 3'd7, 7'd3},  {1'b1, 3'd6, 7'd96}
  };

  periph_clkrst_seq dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .hclk_tick(hclk_tick), .glue_rst(glue_rst), .core_rst(core_rst),
    .unit_en(unit_en), .hclk_wait_done(hclk_wait_done),
    .core_wait_done(core_wait_done), .access_ok(access_ok)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (hclk_tick) n++;
    end
  endtask

  task automatic reset_state_checks();
    check("R1 rd_data", rd_data, 64'h1000_0003);
    check("R1 glue_rst", {63'd0, glue_rst}, 64'd1);
    check("R1 core_rst", {63'd0, core_rst}, 64'd1);
    check("R1 hclk_tick", {63'd0, hclk_tick}, 64'd0);
    check("R1 unit_en", {63'd0, unit_en}, 64'd0);
    check("R1 flags", {61'd0, hclk_wait_done, core_wait_done, access_ok}, 64'd0);
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    reset_state_checks();

    // R2 and R11: field layout, reserved bits, enabled report
    wr(64'hFFFF_FFFF_FFFF_FFFF);
    check("R2 mask readback", rd_data, 64'h7700_0013);
    check("R11 unit_en set", {63'd0, unit_en}, 64'd1);
    wr(64'h1000_0003);
    check("R11 unit_en clear", {63'd0, unit_en}, 64'd0);

    // R3 and R4: divide table and bypass, table driven
    for (int v = 0; v < 9; v++) begin
      wr(HEN | (VEC[v][10] ? BYP : 64'd0) | (64'(VEC[v][9:7]) << 24) | 64'h3);
      repeat (40) @(negedge clk);
      count_ticks(96, n);
      check(VEC[v][10] ? "R4 bypass rate" : "R3 divide rate", 64'(n), 64'(VEC[v][6:0]));
    end

    // R5: gating
    wr(64'h3);
    repeat (3) @(negedge clk);
    count_ticks(50, n);
    check("R5 clock enable clear", 64'(n), 64'd0);
    wr(HEN | DRST | 64'h3);
    repeat (3) @(negedge clk);
    count_ticks(50, n);
    check("R5 divider reset set", 64'(n), 64'd0);

    // R6..R9: release sequence, ratio 4, requests cleared early
    wr(HEN | (64'd2 << 24) | CCLK);
    n = 0; bad = 0;
    for (int i = 0; i < 3000 && !hclk_wait_done; i++) begin
      @(negedge clk);
      if (!hclk_wait_done) begin
        if (hclk_tick) n++;
        if (!glue_rst) bad++;
      end
    end
    check("R6 start window pulses", 64'(n), 64'd20);
    check("R7 glue held before window", 64'(bad), 64'd0);

    n = 0; bad = 0;
    for (int i = 0; i < 3000 && !core_wait_done; i++) begin
      @(negedge clk);
      if (!core_wait_done) begin
        if (!glue_rst && hclk_tick) n++;
        if (!core_rst) bad++;
      end
    end
    check("R8 glue window pulses", 64'(n), 64'd10);
    check("R8 core held before window", 64'(bad), 64'd0);

    n = 0;
    for (int i = 0; i < 3000 && !access_ok; i++) begin
      @(negedge clk);
      if (!access_ok && !core_rst && hclk_tick) n++;
    end
    check("R9 access window pulses", 64'(n), 64'd10);
    check("R8 core released", {62'd0, glue_rst, core_rst}, 64'd0);

    // R10: reassert glue request, then divider reset
    wr(HEN | (64'd2 << 24) | CCLK | 64'h1);
    repeat (4) @(negedge clk);
    check("R10 resets back", {62'd0, glue_rst, core_rst}, 64'd3);
    check("R10 later flags clear", {61'd0, hclk_wait_done, core_wait_done, access_ok}, 64'd4);
    wr(HEN | DRST | (64'd2 << 24) | 64'h1);
    repeat (4) @(negedge clk);
    check("R10 start flag clear", {63'd0, hclk_wait_done}, 64'd0);
    check("R10 tick stopped", {63'd0, hclk_tick}, 64'd0);

    // R1: reset from a running state
    wr(HEN | BYP | CCLK);
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    reset_state_checks();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule